// File: doc/BRIEF.md
# Auto-Negotiation Code Word Arbiter

This block sits behind the pulse-burst decoder of a twisted-pair transceiver. It receives 16-bit link code words, one per `cw_valid` strobe, and decides when the link partner's advertisement has settled. Words are compared with the acknowledge bit (bit 14) masked. Three equal words in a row form a run. The first run stores the partner's word. A second run then triggers resolution against the local abilities, which picks the best mode both sides share. If nothing is shared, the block still finishes but raises a fault.

Two level inputs report parallel detection: one for 10 Mb/s normal link pulses and one for 100 Mb/s idle. Either one ends negotiation at once with the matching speed in half duplex, and it also overrides a mode that was already resolved. A restart request or a loss of link starts the whole process again. The fiber-mode input turns negotiation off completely.

The controller has four states:
- `S_DISABLED`: fiber mode is active.
- `S_COLLECT_A`: waiting for the first run.
- `S_COLLECT_B`: waiting for the second run.
- `S_RESOLVED`: a mode is settled.

Its transitions are:
- `fiber` goes to `S_DISABLED` from any state.
- `release` goes from `S_DISABLED` to `S_COLLECT_A`.
- `restart` (restart request or link loss) goes to `S_COLLECT_A` from any state.
- `first_run` goes from `S_COLLECT_A` to `S_COLLECT_B`.
- `second_run` goes from `S_COLLECT_B` to `S_RESOLVED`.
- `par_detect` goes from either collecting state to `S_RESOLVED`.

Top module: `an_cw_arbiter`

## Requirements
- R1: After reset, `an_done`, `partner_valid`, `speed_100`, `full_duplex` and `an_fault` are 0, and `partner_word` is 0.
- R2: Valid words are compared with bit 14 masked. A valid word that differs from the reference in any other bit becomes the new reference, with a count of one. Only valid strobes count, and idle cycles between them do not break a run.
- R3: The third consecutive matching valid word sets `partner_valid` at the same clock edge, with `an_done` still 0. `partner_word` then holds that third word exactly as received.
- R4: After the first run, a second run of three matching words sets `an_done` at the clock edge of its third word, and `partner_word` takes that word. Once resolved, further code words change no output.
- R5: Resolution takes the highest common ability of `local_abil` and partner bits 8..5. The order is 100 full duplex (partner bit 8, `local_abil[3]`), 100 half duplex (bit 7, `local_abil[2]`), 10 full duplex (bit 6, `local_abil[1]`), then 10 half duplex (bit 5, `local_abil[0]`). `speed_100`=1 means 100 Mb/s and `full_duplex`=1 means full duplex.
- R6: With no common ability, `an_done` and `an_fault` are both 1, and `speed_100` and `full_duplex` are both 0.
- R7: In a collecting state, `pd_idle` or `pd_nlp` sets `an_done` at the next edge, in half duplex. `speed_100` equals `pd_idle`, so idle wins when both are high. Parallel detection beats a run completing in the same cycle. In `S_RESOLVED` it replaces the resolved speed, forces half duplex and clears `an_fault`.
- R8: `restart` or `link_lost` clears every output at the next edge and restarts word collection from nothing.
- R9: While `fiber_mode` is high, every output stays 0 and code words and parallel detection have no effect. After release, collection starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Code word strobe |
| cw_data | input | 16 | Received link code word |
| local_abil | input | 4 | Local abilities {100FD,100HD,10FD,10HD} |
| pd_nlp | input | 1 | Parallel detect: 10 Mb/s link pulses seen |
| pd_idle | input | 1 | Parallel detect: 100 Mb/s idle seen |
| link_lost | input | 1 | Link loss, restarts negotiation |
| restart | input | 1 | Restart request |
| fiber_mode | input | 1 | Disables negotiation |
| partner_word | output | 16 | Stored partner code word |
| partner_valid | output | 1 | First run captured |
| speed_100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| full_duplex | output | 1 | Resolved duplex, 1 = full |
| an_done | output | 1 | Negotiation complete |
| an_fault | output | 1 | No common ability |

## Verification
The assertions assume that `local_abil` is held steady while a second run completes, and that the parallel-detect inputs are ordinary synchronous levels, with no meaning given to pulse length. The stimulus changes `local_abil` only after a restart, before any words are sent. It drives every input on the falling clock edge and holds each detect input for exactly one cycle. Randomised words keep the acknowledge bit toggling within each run, so the masking is exercised without breaking the run.

// File: rtl/an_arb_pkg.sv
package an_arb_pkg;

    typedef enum logic [1:0] {
        S_DISABLED  = 2'd0,
        S_COLLECT_A = 2'd1,
        S_COLLECT_B = 2'd2,
        S_RESOLVED  = 2'd3
    } an_state_e;

    typedef struct packed {
        logic spd100;
        logic fdx;
        logic fault;
    } an_mode_t;

    localparam int unsigned ACK_POS   = 14;
    localparam int unsigned ABIL_TOP  = 8;
    localparam int unsigned NUM_ABIL  = 4;

endpackage

// File: rtl/an_run_detector.sv
module an_run_detector #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned RUN_LEN = 3,
    parameter int unsigned ACK_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cw_valid,
    input  logic [WORD_W-1:0] cw_data,
    output logic              run_hit,
    output logic [WORD_W-1:0] run_word
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [WORD_W-1:0] CMP_MASK = ~(WORD_W'(1) << ACK_BIT);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_LEN - 1);

    logic [WORD_W-1:0] ref_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              match;

    assign match    = (cnt_q != '0) && ((cw_data & CMP_MASK) == (ref_q & CMP_MASK));
    assign run_hit  = cw_valid && match && (cnt_q == LAST_CNT);
    assign run_word = cw_data;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_q <= '0;
            cnt_q <= '0;
        end else if (cw_valid) begin
            if (run_hit) begin
                cnt_q <= '0;
            end else if (match) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else begin
                ref_q <= cw_data;
                cnt_q <= CNT_W'(1);
            end
        end
    end

    // R3: the count never reaches the run length; a full run restarts it
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(RUN_LEN));

    // R2: a differing word becomes the reference with a count of one
    p_mismatch_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !match && !clear) |=> (cnt_q == CNT_W'(1)) && (ref_q == $past(cw_data)));

endmodule

// File: rtl/an_priority_resolve.sv
module an_priority_resolve
    import an_arb_pkg::*;
(
    input  logic [NUM_ABIL-1:0] local_abil,
    input  logic [NUM_ABIL-1:0] partner_abil,
    output an_mode_t            mode
);
    logic [NUM_ABIL-1:0] common;
    logic [NUM_ABIL-1:0] pick;

    generate
        for (genvar g = 0; g < NUM_ABIL; g++) begin : g_common
            assign common[g] = local_abil[g] & partner_abil[g];
        end
    endgenerate

    // highest index wins: 3 = 100FD, 2 = 100HD, 1 = 10FD, 0 = 10HD
    always_comb begin
        pick = '0;
        for (int i = NUM_ABIL - 1; i >= 0; i--) begin
            if (common[i] && (pick == '0)) begin
                pick[i] = 1'b1;
            end
        end
    end

    always_comb begin
        mode.spd100 = pick[3] | pick[2];
        mode.fdx    = pick[3] | pick[1];
        mode.fault  = (common == '0);
    end

    // R5: exactly one mode is chosen unless nothing is shared
    always_comb begin
        p_pick_onehot_r5: assert (mode.fault ? (pick == '0) : $onehot(pick));
    end

endmodule

// File: rtl/an_cw_arbiter.sv
module an_cw_arbiter
    import an_arb_pkg::*;
#(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned RUN_LEN = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cw_valid,
    input  logic [WORD_W-1:0]   cw_data,
    input  logic [NUM_ABIL-1:0] local_abil,
    input  logic                pd_nlp,
    input  logic                pd_idle,
    input  logic                link_lost,
    input  logic                restart,
    input  logic                fiber_mode,
    output logic [WORD_W-1:0]   partner_word,
    output logic                partner_valid,
    output logic                speed_100,
    output logic                full_duplex,
    output logic                an_done,
    output logic                an_fault
);
    an_state_e         state_q;
    an_state_e         state_d;
    logic              restart_req;
    logic              pd_any;
    logic              det_clear;
    logic              run_hit;
    logic [WORD_W-1:0] run_word;
    an_mode_t          res_mode;

    assign restart_req = restart | link_lost;
    assign pd_any      = pd_nlp | pd_idle;
    assign det_clear   = fiber_mode | restart_req | (state_q == S_DISABLED);

    an_run_detector #(
        .WORD_W  (WORD_W),
        .RUN_LEN (RUN_LEN),
        .ACK_BIT (ACK_POS)
    ) u_runs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (det_clear),
        .cw_valid (cw_valid),
        .cw_data  (cw_data),
        .run_hit  (run_hit),
        .run_word (run_word)
    );

    an_priority_resolve u_resolve (
        .local_abil   (local_abil),
        .partner_abil (run_word[ABIL_TOP -: NUM_ABIL]),
        .mode         (res_mode)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_DISABLED: begin
                state_d = S_COLLECT_A;                       // release
            end
            S_COLLECT_A: begin
                if (pd_any) begin
                    state_d = S_RESOLVED;                    // par_detect
                end else if (run_hit) begin
                    state_d = S_COLLECT_B;                   // first_run
                end
            end
            S_COLLECT_B: begin
                if (pd_any || run_hit) begin
                    state_d = S_RESOLVED;                    // par_detect / second_run
                end
            end
            S_RESOLVED: begin
                state_d = S_RESOLVED;
            end
        endcase
        if (restart_req) begin
            state_d = S_COLLECT_A;                           // restart
        end
        if (fiber_mode) begin
            state_d = S_DISABLED;                            // fiber
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_COLLECT_A;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n || fiber_mode || restart_req) begin
            partner_word  <= '0;
            partner_valid <= 1'b0;
            speed_100     <= 1'b0;
            full_duplex   <= 1'b0;
            an_done       <= 1'b0;
            an_fault      <= 1'b0;
        end else begin
            unique case (state_q)
                S_DISABLED: begin
                    an_done <= 1'b0;
                end
                S_COLLECT_A: begin
                    if (pd_any) begin
                        an_done     <= 1'b1;
                        speed_100   <= pd_idle;
                        full_duplex <= 1'b0;
                        an_fault    <= 1'b0;
                    end else if (run_hit) begin
                        partner_word  <= run_word;
                        partner_valid <= 1'b1;
                    end
                end
                S_COLLECT_B: begin
                    if (pd_any) begin
                        an_done     <= 1'b1;
                        speed_100   <= pd_idle;
                        full_duplex <= 1'b0;
                        an_fault    <= 1'b0;
                    end else if (run_hit) begin
                        partner_word <= run_word;
                        an_done      <= 1'b1;
                        speed_100    <= res_mode.spd100;
                        full_duplex  <= res_mode.fdx;
                        an_fault     <= res_mode.fault;
                    end
                end
                S_RESOLVED: begin
                    if (pd_any) begin
                        speed_100   <= pd_idle;
                        full_duplex <= 1'b0;
                        an_fault    <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R3: the first run stores the word but does not finish
    p_first_run_stores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COLLECT_A && run_hit && !pd_any && !restart_req && !fiber_mode)
        |=> (partner_valid && !an_done && partner_word == $past(cw_data)));

    // R4: the second run finishes negotiation
    p_second_run_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COLLECT_B && run_hit && !pd_any && !restart_req && !fiber_mode)
        |=> an_done);

    // R4: a resolved result is frozen against further words
    p_resolved_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESOLVED && !pd_any && !restart_req && !fiber_mode)
        |=> ($stable(partner_word) && $stable(speed_100) && $stable(full_duplex) && an_done));

    // R6: a fault always reports 10 Mb/s half duplex with done
    p_fault_slow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        an_fault |-> (an_done && !speed_100 && !full_duplex));

    // R7: parallel detection finishes in half duplex at the detected speed
    p_pd_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_DISABLED && pd_any && !restart_req && !fiber_mode)
        |=> (an_done && !full_duplex && !an_fault && speed_100 == $past(pd_idle)));

    // R8: restart or link loss clears the result
    p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_req && !fiber_mode)
        |=> (!an_done && !partner_valid && state_q == S_COLLECT_A));

    // R9: fiber mode keeps negotiation off
    p_fiber_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_mode |=> (!an_done && !partner_valid && state_q == S_DISABLED));

endmodule

// File: tb/an_cw_arbiter_test.sv
module an_cw_arbiter_test;

    localparam logic [15:0] ACKM = 16'h4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_valid = 1'b0;
    logic [15:0] cw_data = '0;
    logic [3:0]  local_abil = 4'hF;
    logic        pd_nlp = 1'b0;
    logic        pd_idle = 1'b0;
    logic        link_lost = 1'b0;
    logic        restart = 1'b0;
    logic        fiber_mode = 1'b0;
    logic [15:0] partner_word;
    logic        partner_valid;
    logic        speed_100;
    logic        full_duplex;
    logic        an_done;
    logic        an_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    an_cw_arbiter uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cw_valid      (cw_valid),
        .cw_data       (cw_data),
        .local_abil    (local_abil),
        .pd_nlp        (pd_nlp),
        .pd_idle       (pd_idle),
        .link_lost     (link_lost),
        .restart       (restart),
        .fiber_mode    (fiber_mode),
        .partner_word  (partner_word),
        .partner_valid (partner_valid),
        .speed_100     (speed_100),
        .full_duplex   (full_duplex),
        .an_done       (an_done),
        .an_fault      (an_fault)
    );

    // expected {done, spd100, fdx, fault} from the priority rule
    function automatic logic [3:0] exp_mode(input logic [3:0] loc, input logic [15:0] par);
        logic [3:0] c;
        c = loc & par[8:5];
        if (c[3])      return 4'b1110;
        else if (c[2]) return 4'b1100;
        else if (c[1]) return 4'b1010;
        else if (c[0]) return 4'b1000;
        else           return 4'b1001;
    endfunction

    // {done, spd, fdx, fault, pvalid, word}
    task automatic check(input string tag, input logic [3:0] e_mode,
                         input logic e_pv, input logic [15:0] e_word);
        logic [20:0] act;
        logic [20:0] exp;
        act = {an_done, speed_100, full_duplex, an_fault, partner_valid, partner_word};
        exp = {e_mode, e_pv, e_word};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cw_valid = 1'b1;
        cw_data  = w;
        @(negedge clk);
        cw_valid = 1'b0;
    endtask

    task automatic send_pd(input logic [15:0] w, input logic v, input logic nlp, input logic idle);
        @(negedge clk);
        cw_valid = v;
        cw_data  = w;
        pd_nlp   = nlp;
        pd_idle  = idle;
        @(negedge clk);
        cw_valid = 1'b0;
        pd_nlp   = 1'b0;
        pd_idle  = 1'b0;
    endtask

    task automatic do_restart(input logic use_link);
        @(negedge clk);
        if (use_link) link_lost = 1'b1; else restart = 1'b1;
        @(negedge clk);
        link_lost = 1'b0;
        restart   = 1'b0;
    endtask

    task automatic run3(input logic [15:0] w);
        send(w);
        send(w ^ ACKM);
        send(w);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] a;
        logic [15:0] b;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 reset state", 4'b0000, 1'b0, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 after release", 4'b0000, 1'b0, 16'h0000);

        // R3: first run with ack toggling, stored as received
        local_abil = 4'b1111;
        send(16'h41E1);
        send(16'h01E1);
        check("R3 no store after two", 4'b0000, 1'b0, 16'h0000);
        send(16'h41E1);
        check("R3 first run stored", 4'b0000, 1'b1, 16'h41E1);

        // R4: second run resolves, 100FD
        run3(16'h01E1);
        check("R4 second run resolves", exp_mode(4'b1111, 16'h01E1), 1'b1, 16'h01E1);

        // R4: further runs ignored
        run3(16'h0021);
        check("R4 frozen after resolve", exp_mode(4'b1111, 16'h01E1), 1'b1, 16'h01E1);

        // R8: restart clears
        do_restart(1'b0);
        check("R8 restart clears", 4'b0000, 1'b0, 16'h0000);

        // R2: mismatch restarts the count
        send(16'h0021);
        send(16'h0021);
        send(16'h0121);
        send(16'h4121);
        check("R2 mismatch restarts count", 4'b0000, 1'b0, 16'h0000);
        send(16'h0121);
        check("R2 new reference completes", 4'b0000, 1'b1, 16'h0121);

        // R5: 10FD chosen when 100 not shared
        local_abil = 4'b0011;
        run3(16'h0161);
        check("R5 picks 10FD", exp_mode(4'b0011, 16'h0161), 1'b1, 16'h0161);

        // R6: nothing shared -> fault
        do_restart(1'b1);
        check("R8 link loss clears", 4'b0000, 1'b0, 16'h0000);
        local_abil = 4'b1000;
        run3(16'h0021);
        run3(16'h0021);
        check("R6 no common ability", 4'b1001, 1'b1, 16'h0021);

        // R7: override in resolved state clears fault
        send_pd(16'h0, 1'b0, 1'b1, 1'b0);
        check("R7 override resolved", 4'b1000, 1'b1, 16'h0021);

        // R7: pd_idle during first collect
        do_restart(1'b0);
        send_pd(16'h0, 1'b0, 1'b0, 1'b1);
        check("R7 idle gives 100 HD", 4'b1100, 1'b0, 16'h0000);

        // R7: both detected -> 100
        do_restart(1'b0);
        send_pd(16'h0, 1'b0, 1'b1, 1'b1);
        check("R7 both gives 100 HD", 4'b1100, 1'b0, 16'h0000);

        // R7: detect beats second run completing
        do_restart(1'b0);
        local_abil = 4'b1111;
        run3(16'h01E1);
        send(16'h01E1);
        send(16'h01E1);
        send_pd(16'h01E1, 1'b1, 1'b1, 1'b0);
        check("R7 detect beats run", 4'b1000, 1'b1, 16'h01E1);

        // R9: fiber mode
        @(negedge clk);
        fiber_mode = 1'b1;
        run3(16'h01E1);
        run3(16'h01E1);
        send_pd(16'h0, 1'b0, 1'b1, 1'b1);
        check("R9 fiber holds off", 4'b0000, 1'b0, 16'h0000);
        @(negedge clk);
        fiber_mode = 1'b0;
        repeat (2) @(negedge clk);
        run3(16'h0081);
        run3(16'h0081);
        check("R9 fresh after release", exp_mode(4'b1111, 16'h0081), 1'b1, 16'h0081);

        // random runs, R4 and R5
        for (int k = 0; k < 40; k++) begin
            do_restart(k[0]);
            local_abil = 4'($urandom);
            a = 16'($urandom);
            b = 16'($urandom);
            if (k[1]) send(a ^ 16'h0100);
            send(a);
            send(a ^ ACKM);
            send(a ^ (($urandom & 1) != 0 ? ACKM : 16'h0));
            check("R3 random first run", 4'b0000, 1'b1, partner_word_exp(a));
            send(b ^ ACKM);
            send(b);
            send(b);
            check("R5 random resolve", exp_mode(local_abil, b), 1'b1, b);
        end

        finished = 1'b1;
        summary();
    end

    // the third word of the first random run: a with the ack bit of its last send
    logic [15:0] last_sent;
    always @(posedge clk) if (cw_valid) last_sent <= cw_data;
    function automatic logic [15:0] partner_word_exp(input logic [15:0] base);
        return (last_sent & ACKM) | (base & ~ACKM);
    endfunction

endmodule